// File: doc/BRIEF.md
# 54-bit Alarm Timer

This block is a 54-bit time-base counter that counts up or down on ticks from a 16-bit prescaler. Its count is compared against a programmable 54-bit alarm value. When the alarm fires, the block can optionally reload the counter from a separate 54-bit load value. Software can also force that reload at any time with a single register write.

Software reaches the block through a write-only register port. Wide values are split into a 32-bit low word and a 22-bit high word. The count is never read live. A write to the snapshot address copies the count into a pair of readback outputs, which then hold until the next snapshot. A level interrupt comes from a raw alarm flag gated by an enable bit. The flag is cleared by writing a one. A single clock-enable input selects which clock cycles the prescaler may count.

Top module: `alarm_timer54`

## Requirements
- R1: After reset, `irq_o`, `irq_raw_o` and `alarm_armed_o` are 0, and both snapshot outputs are 0.
- R2: Register addresses are: 0 config, 1 snapshot, 2 alarm low, 3 alarm high, 4 load low, 5 load high, 6 reload trigger, 8 interrupt enable (data bit 0), 9 interrupt clear (data bit 0). A write of any data to address 6 puts the 54-bit load value into the counter at that clock edge. If a prescaler tick falls on the same edge, the load wins.
- R3: The config word holds run (bit 0), up (bit 1), auto-reload (bit 2), alarm-arm (bit 3), prescaler restart (bit 4, not stored) and divide value D (bits 31:16). Reset values are run=0, up=1, auto-reload=1, arm=0, D=1. Counting up, the counter moves once every D stepping cycles. D=0 behaves as D=1. Setting bit 4 zeroes the prescaler phase.
- R4: With up=0 the counter decrements once per prescaler tick.
- R5: The prescaler and counter step only on cycles where run=1 and `clk_en_i`=1. Otherwise the count holds.
- R6: The count wraps modulo 2^54 in both directions.
- R7: A write to address 1 copies the count into `snap_lo_o`/`snap_hi_o` on that edge. Without such a write, the snapshot outputs hold.
- R8: While armed, a count equal to the alarm value sets `irq_raw_o` and clears `alarm_armed_o` one edge later. The alarm then stays quiet until it is re-armed.
- R9: With auto-reload set, the alarm edge loads the load value into the counter instead of stepping it.
- R10: `irq_o` is `irq_raw_o` AND the enable bit. Writing 1 in bit 0 of address 9 clears `irq_raw_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clk_en_i | input | 1 | Qualifies cycles on which the prescaler may step |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 4 | Register write address |
| wr_data_i | input | 32 | Register write data |
| snap_lo_o | output | 32 | Snapshot of count bits 31:0 |
| snap_hi_o | output | 22 | Snapshot of count bits 53:32 |
| alarm_armed_o | output | 1 | Alarm comparator is armed |
| irq_raw_o | output | 1 | Raw alarm interrupt flag |
| irq_o | output | 1 | Masked interrupt |

## Verification
A register write lands on the edge that samples it, so a reload or snapshot is visible right after that edge. The raw flag and the arm bit change one edge after the cycle in which the count equals the alarm. A run that starts with a config write at edge 0 and stops with another config write m edges later steps the prescaler m+1 times. The expected count is therefore floor((m+1)/D) ticks from the loaded value. Every write task consumes exactly one rising edge, and all sampling happens on the falling edge. This lets the bench functions count edges exactly and compare the snapshot and flags at the precise cycle each result is due.

// File: rtl/t54_pkg.sv
package t54_pkg;
    localparam int CNT_W  = 54;
    localparam int WORD_W = 32;
    localparam int DIV_W  = 16;
    localparam int ADDR_W = 4;

    typedef enum logic [ADDR_W-1:0] {
        A_CFG    = 4'd0,
        A_SNAP   = 4'd1,
        A_ALM_LO = 4'd2,
        A_ALM_HI = 4'd3,
        A_LD_LO  = 4'd4,
        A_LD_HI  = 4'd5,
        A_RELOAD = 4'd6,
        A_IEN    = 4'd8,
        A_ICLR   = 4'd9
    } reg_addr_e;

    localparam int CFG_RUN     = 0;
    localparam int CFG_UP      = 1;
    localparam int CFG_AUTO    = 2;
    localparam int CFG_ARM     = 3;
    localparam int CFG_DIVRST  = 4;
    localparam int CFG_DIV_LSB = 16;
endpackage

// File: rtl/t54_prescaler.sv
module t54_prescaler #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_i,
    input  logic             restart_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             tick_o
);
    typedef struct packed {
        logic [DIV_W-1:0] phase;
    } pre_st_t;

    localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

    pre_st_t st_d, st_q;
    logic [DIV_W-1:0] limit;

    always_comb begin
        limit  = (div_i == '0) ? '0 : div_i - ONE;
        tick_o = step_i && !restart_i && (st_q.phase >= limit);
        st_d   = st_q;
        if (restart_i) begin
            st_d.phase = '0;
        end else if (step_i) begin
            st_d.phase = tick_o ? '0 : st_q.phase + ONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R3: a tick always restarts the phase
    assert_tick_phase_R3: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> st_q.phase == '0);

    // R5: no step and no restart leaves the phase alone
    assert_phase_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!step_i && !restart_i) |=> $stable(st_q.phase));
endmodule

// File: rtl/t54_counter.sv
module t54_counter #(
    parameter int CNT_W = 54
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             up_i,
    input  logic             load_now_i,
    input  logic             auto_i,
    input  logic             armed_i,
    input  logic [CNT_W-1:0] alarm_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic [CNT_W-1:0] count_o,
    output logic             hit_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_st_t;

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    cnt_st_t st_d, st_q;

    always_comb begin
        hit_o = armed_i && (st_q.cnt == alarm_i);
        st_d  = st_q;
        if (load_now_i || (hit_o && auto_i)) begin
            st_d.cnt = load_val_i;
        end else if (tick_i) begin
            st_d.cnt = up_i ? st_q.cnt + ONE : st_q.cnt - ONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count_o = st_q.cnt;

    // R2: software reload lands on the next edge, ticks notwithstanding
    assert_sw_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        load_now_i |=> count_o == $past(load_val_i));

    // R9: alarm with auto-reload restores the load value
    assert_auto_reload_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_o && auto_i) |=> count_o == $past(load_val_i));

    // R5: without tick or load the count holds
    assert_count_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !load_now_i && !(hit_o && auto_i)) |=> $stable(count_o));

    // R3: an up tick adds exactly one, modulo the width
    assert_up_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && up_i && !load_now_i && !(hit_o && auto_i))
            |=> count_o == $past(count_o) + ONE);
endmodule

// File: rtl/t54_irq.sv
module t54_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    input  logic en_wr_i,
    input  logic en_val_i,
    output logic raw_o,
    output logic irq_o
);
    typedef struct packed {
        logic raw;
        logic en;
    } irq_st_t;

    irq_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (set_i)      st_d.raw = 1'b1;
        else if (clr_i) st_d.raw = 1'b0;
        if (en_wr_i)    st_d.en  = en_val_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign raw_o = st_q.raw;
    assign irq_o = st_q.raw & st_q.en;

    // R8: an alarm event raises the raw flag
    assert_raw_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> raw_o);

    // R10: write-one-to-clear drops the raw flag
    assert_raw_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> !raw_o);
endmodule

// File: rtl/alarm_timer54.sv
module alarm_timer54 #(
    parameter int CNT_W  = t54_pkg::CNT_W,
    parameter int WORD_W = t54_pkg::WORD_W,
    parameter int DIV_W  = t54_pkg::DIV_W,
    parameter int ADDR_W = t54_pkg::ADDR_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clk_en_i,
    input  logic                    wr_en_i,
    input  logic [ADDR_W-1:0]       wr_addr_i,
    input  logic [WORD_W-1:0]       wr_data_i,
    output logic [WORD_W-1:0]       snap_lo_o,
    output logic [CNT_W-WORD_W-1:0] snap_hi_o,
    output logic                    alarm_armed_o,
    output logic                    irq_raw_o,
    output logic                    irq_o
);
    import t54_pkg::*;

    localparam int HI_W = CNT_W - WORD_W;

    typedef struct packed {
        logic             run;
        logic             up;
        logic             autold;
        logic [DIV_W-1:0] div;
    } cfg_t;

    typedef struct packed {
        cfg_t             cfg;
        logic             armed;
        logic [CNT_W-1:0] alarm;
        logic [CNT_W-1:0] load;
        logic [CNT_W-1:0] snap;
    } top_st_t;

    top_st_t st_d, st_q;

    logic wr_cfg, wr_snap, wr_alo, wr_ahi, wr_llo, wr_lhi, wr_rel, wr_ien, wr_iclr;
    logic restart, step, tick, hit;
    logic [CNT_W-1:0] count;

    always_comb begin
        wr_cfg  = wr_en_i && (wr_addr_i == ADDR_W'(A_CFG));
        wr_snap = wr_en_i && (wr_addr_i == ADDR_W'(A_SNAP));
        wr_alo  = wr_en_i && (wr_addr_i == ADDR_W'(A_ALM_LO));
        wr_ahi  = wr_en_i && (wr_addr_i == ADDR_W'(A_ALM_HI));
        wr_llo  = wr_en_i && (wr_addr_i == ADDR_W'(A_LD_LO));
        wr_lhi  = wr_en_i && (wr_addr_i == ADDR_W'(A_LD_HI));
        wr_rel  = wr_en_i && (wr_addr_i == ADDR_W'(A_RELOAD));
        wr_ien  = wr_en_i && (wr_addr_i == ADDR_W'(A_IEN));
        wr_iclr = wr_en_i && (wr_addr_i == ADDR_W'(A_ICLR));
        restart = wr_cfg && wr_data_i[CFG_DIVRST];
        step    = st_q.cfg.run && clk_en_i;
    end

    always_comb begin
        st_d = st_q;
        if (wr_cfg) begin
            st_d.cfg.run    = wr_data_i[CFG_RUN];
            st_d.cfg.up     = wr_data_i[CFG_UP];
            st_d.cfg.autold = wr_data_i[CFG_AUTO];
            st_d.cfg.div    = wr_data_i[CFG_DIV_LSB +: DIV_W];
            st_d.armed      = wr_data_i[CFG_ARM];
        end else if (hit) begin
            st_d.armed = 1'b0;
        end
        if (wr_alo) st_d.alarm[WORD_W-1:0]     = wr_data_i;
        if (wr_ahi) st_d.alarm[CNT_W-1:WORD_W] = wr_data_i[HI_W-1:0];
        if (wr_llo) st_d.load[WORD_W-1:0]      = wr_data_i;
        if (wr_lhi) st_d.load[CNT_W-1:WORD_W]  = wr_data_i[HI_W-1:0];
        if (wr_snap) st_d.snap = count;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q            <= '0;
            st_q.cfg.up     <= 1'b1;
            st_q.cfg.autold <= 1'b1;
            st_q.cfg.div    <= DIV_W'(1);
        end else begin
            st_q <= st_d;
        end
    end

    t54_prescaler #(.DIV_W(DIV_W)) u_pre (
        .clk       (clk),
        .rst_n     (rst_n),
        .step_i    (step),
        .restart_i (restart),
        .div_i     (st_q.cfg.div),
        .tick_o    (tick)
    );

    t54_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (tick),
        .up_i       (st_q.cfg.up),
        .load_now_i (wr_rel),
        .auto_i     (st_q.cfg.autold),
        .armed_i    (st_q.armed),
        .alarm_i    (st_q.alarm),
        .load_val_i (st_q.load),
        .count_o    (count),
        .hit_o      (hit)
    );

    t54_irq u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_i    (hit),
        .clr_i    (wr_iclr && wr_data_i[0]),
        .en_wr_i  (wr_ien),
        .en_val_i (wr_data_i[0]),
        .raw_o    (irq_raw_o),
        .irq_o    (irq_o)
    );

    assign snap_lo_o     = st_q.snap[WORD_W-1:0];
    assign snap_hi_o     = st_q.snap[CNT_W-1:WORD_W];
    assign alarm_armed_o = st_q.armed;

    // R8: the alarm disarms itself unless software rewrites the config
    assert_arm_selfclear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && !wr_cfg) |=> !alarm_armed_o);

    // R7: snapshot captures the count of the write cycle
    assert_snap_take_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_snap |=> {snap_hi_o, snap_lo_o} == $past(count));

    // R7: snapshot holds between writes
    assert_snap_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_snap |=> $stable({snap_hi_o, snap_lo_o}));
endmodule

// File: tb/sim_alarm_timer54.sv
`timescale 1ns/1ps
module sim_alarm_timer54;
    import t54_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clk_en = 1'b1;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] snap_lo;
    logic [21:0] snap_hi;
    logic        armed, raw, irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    alarm_timer54 u0 (
        .clk(clk), .rst_n(rst_n), .clk_en_i(clk_en),
        .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
        .snap_lo_o(snap_lo), .snap_hi_o(snap_hi),
        .alarm_armed_o(armed), .irq_raw_o(raw), .irq_o(irq)
    );

    function automatic logic [31:0] mk_cfg(bit run, bit up, bit autold, bit arm,
                                           bit divrst, logic [15:0] div);
        logic [31:0] w = '0;
        w[CFG_RUN]    = run;
        w[CFG_UP]     = up;
        w[CFG_AUTO]   = autold;
        w[CFG_ARM]    = arm;
        w[CFG_DIVRST] = divrst;
        w[CFG_DIV_LSB +: 16] = div;
        return w;
    endfunction

    function automatic logic [53:0] exp_count(logic [53:0] start, bit up,
                                              int edges, logic [15:0] div);
        int n = edges / ((div == 16'd0) ? 1 : int'(div));
        return up ? start + 54'(n) : start - 54'(n);
    endfunction

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // called at a falling edge; consumes exactly one rising edge
    task automatic wr(logic [3:0] a, logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic set_load(logic [53:0] v);
        wr(A_LD_LO, v[31:0]);
        wr(A_LD_HI, {10'd0, v[53:32]});
    endtask

    task automatic reload_to(logic [53:0] v);
        set_load(v);
        wr(A_RELOAD, 32'hDEAD_BEEF);
    endtask

    task automatic set_alarm(logic [53:0] v);
        wr(A_ALM_LO, v[31:0]);
        wr(A_ALM_HI, {10'd0, v[53:32]});
    endtask

    task automatic snap(output logic [53:0] v);
        wr(A_SNAP, 32'h0);
        v = {snap_hi, snap_lo};
    endtask

    // start edge plus m waiting edges plus the stop edge: m+1 stepping edges
    task automatic run_for(bit up, logic [15:0] div, int m, bit autold, bit arm);
        wr(A_CFG, mk_cfg(1'b1, up, autold, arm, 1'b1, div));
        repeat (m) @(negedge clk);
        wr(A_CFG, mk_cfg(1'b0, up, autold, 1'b0, 1'b0, div));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual hung expected finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [53:0] got, l, l2;
        int seed;
        seed = $urandom(32'h5EED);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 irq", irq, 0);
        chk("R1 raw", raw, 0);
        chk("R1 armed", armed, 0);
        chk("R1 snapshot", {snap_hi, snap_lo}, 0);

        // R2 software reload
        l = 54'h2A_BCDE_F012_3456;
        reload_to(l);
        snap(got);
        chk("R2 reload", got, l);

        // R5 idle with run=0 holds
        repeat (5) @(negedge clk);
        snap(got);
        chk("R5 run off hold", got, l);

        // R5 clk_en low holds even while running
        clk_en = 1'b0;
        run_for(1'b1, 16'd1, 6, 1'b0, 1'b0);
        clk_en = 1'b1;
        snap(got);
        chk("R5 clk_en low hold", got, l);

        // R3 divider 3 up count
        reload_to(54'd100);
        run_for(1'b1, 16'd3, 10, 1'b0, 1'b0);
        snap(got);
        chk("R3 div3 up", got, exp_count(54'd100, 1'b1, 11, 16'd3));

        // R3 divider 0 acts as 1
        reload_to(54'd7);
        run_for(1'b1, 16'd0, 4, 1'b0, 1'b0);
        snap(got);
        chk("R3 div0", got, 54'd12);

        // R4 down count
        reload_to(54'd50);
        run_for(1'b0, 16'd2, 7, 1'b0, 1'b0);
        snap(got);
        chk("R4 down", got, 54'd46);

        // R6 wrap upward and downward
        reload_to({54{1'b1}} - 54'd1);
        run_for(1'b1, 16'd1, 4, 1'b0, 1'b0);
        snap(got);
        chk("R6 wrap up", got, 54'd3);
        reload_to(54'd1);
        run_for(1'b0, 16'd1, 2, 1'b0, 1'b0);
        snap(got);
        chk("R6 wrap down", got, {54{1'b1}} - 54'd1);

        // R3 R4 constrained random runs
        for (int i = 0; i < 12; i++) begin
            logic [15:0] div;
            bit up;
            int m;
            l   = {22'($urandom), $urandom};
            up  = 1'($urandom % 2);
            div = 16'($urandom % 5);
            m   = int'($urandom % 20);
            reload_to(l);
            run_for(up, div, m, 1'b0, 1'b0);
            snap(got);
            chk(up ? "R3 random up" : "R4 random down", got, exp_count(l, up, m + 1, div));
        end

        // R2 reload beats a tick on the same edge
        l  = 54'd1000;
        l2 = 54'h3F_0000_0000_0010;
        reload_to(l);
        set_load(l2);
        wr(A_CFG, mk_cfg(1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 16'd1));
        repeat (3) @(negedge clk);
        wr(A_RELOAD, 32'h0);
        wr(A_CFG, mk_cfg(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 16'd1));
        snap(got);
        chk("R2 reload over tick", got, l2 + 54'd1);

        // R7 snapshot holds while the counter runs
        wr(A_CFG, mk_cfg(1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 16'd1));
        repeat (5) @(negedge clk);
        chk("R7 snapshot stable", {snap_hi, snap_lo}, l2 + 54'd1);
        wr(A_CFG, mk_cfg(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 16'd1));

        // R8 alarm timing, self-clearing arm, no auto-reload
        l = 54'h00_1234_5678_0000;
        reload_to(l);
        set_alarm(l + 54'd3);
        wr(A_IEN, 32'd1);
        wr(A_CFG, mk_cfg(1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 16'd1));
        chk("R8 armed after config", armed, 1);
        repeat (3) @(negedge clk);
        chk("R8 raw not yet", raw, 0);
        @(negedge clk);
        chk("R8 raw set", raw, 1);
        chk("R8 arm cleared", armed, 0);
        chk("R10 irq on", irq, 1);
        wr(A_CFG, mk_cfg(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 16'd1));
        snap(got);
        chk("R8 no reload when auto off", got, l + 54'd5);

        // R10 mask and clear
        wr(A_IEN, 32'd0);
        chk("R10 masked irq", irq, 0);
        chk("R10 raw kept", raw, 1);
        wr(A_ICLR, 32'd1);
        chk("R10 raw cleared", raw, 0);
        wr(A_IEN, 32'd1);

        // R9 auto-reload on alarm, and R8 fires only once
        l = 54'd500;
        reload_to(l);
        set_alarm(l + 54'd2);
        run_for(1'b1, 16'd1, 8, 1'b1, 1'b1);
        snap(got);
        chk("R9 auto reload once", got, l + 54'd6);
        chk("R8 raw from auto run", raw, 1);
        chk("R8 disarmed after auto run", armed, 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule